// File: doc/BRIEF.md
# Column Cholesky Engine

This block computes one column of a Cholesky factor in place. A symmetric positive-definite matrix of order n (up to 16) lives in a shared memory. Only its lower triangle is used, and each entry sits at address `row*16 + col`, with the row in the upper address bits. Once started on column j, the engine performs three steps:

- For each earlier column k, taken in increasing order, it waits until the caller marks column k as finished. It then subtracts `A[j][k]*A[i][k]` from every entry `A[i][j]` with row i from j to n-1.
- It replaces the diagonal with its square root.
- It divides every entry below the diagonal by that root.

All values are signed fixed point with 16 fraction bits, held in 32-bit words. The square root and the divide are computed by bit-serial units inside the block.

A scheduler above the block chooses which column to run. It feeds back, as a bit vector, the columns that are already complete. It collects the one-cycle completion pulse the engine raises for each finished column. Several engines may share the memory through an external arbiter. The dependency vector is the only coupling between columns.

Top module: `chol_col_engine`

## Requirements
- R1: After reset the block is idle: busy, done, error, write enable and the completion pulse are all low.
- R2: A modify step for column k rewrites `A[i][j]` as `A[i][j] - ((A[j][k]*A[i][k]) >>> 16)`, keeping the low 32 bits, for each row i from j to n-1, in place.
- R3: All modify steps run in increasing k order, from 0 to j-1, and all of them finish before the square root of the diagonal is taken.
- R4: Before the modify step for column k, the block stalls with no memory write while bit k of `ready_i` is low. It resumes when the bit rises.
- R5: The diagonal becomes `floor(sqrt(d * 2^16))`. Each entry below it becomes `(a * 2^16) / root`, truncated toward zero, keeping the low 32 bits.
- R6: For column 0 there is no modify step, and the block completes regardless of `ready_i`.
- R7: On successful completion, `rdy_set_o` is high for exactly one cycle, in the same cycle as `done_o`, with `rdy_col_o` equal to the column index.
- R8: If the diagonal read before the square root is zero or negative, the block sets `err_o`, pulses `done_o`, writes nothing more and gives no completion pulse. The next start clears `err_o`.
- R9: A start request that arrives while busy is ignored.
- R10: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. `done_o` is a single-cycle pulse.
- R11: Memory locations outside rows j..n-1 of column j are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| col_i | input | 4 | Column index j, zero based |
| order_i | input | 5 | Matrix order n, from 1 to 16 |
| busy_o | output | 1 | Column in progress |
| done_o | output | 1 | One-cycle end-of-column strobe |
| err_o | output | 1 | Non-positive diagonal found in the last run |
| rdy_set_o | output | 1 | One-cycle pulse marking the column finished |
| rdy_col_o | output | 4 | Column index belonging to `rdy_set_o` |
| ready_i | input | 16 | Bit k high once column k is finished |
| mem_addr_o | output | 8 | Memory address, `{row, col}` |
| mem_wdata_o | output | 32 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the address |

## Verification
The assertions watch sequencing rules on every cycle:

- the engine holds in its wait while the needed ready bit is low;
- the diagonal is read only after the modify counter has reached j;
- the completion pulse lasts one cycle and never coincides with the error flag;
- writes happen only while busy, and the block goes idle after done;
- the two arithmetic units each raise a single-cycle strobe.

Only the bench scenarios can show the numerical results. The bench compares them against a reference factorization that uses the same fixed-point rounding. The scenarios also show that a start during a run is ignored, that no location outside the column changes, and how zero and negative diagonals are handled.

// File: rtl/chol_pkg.sv
package chol_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_WAIT, S_LJK, S_CJK, S_LIK, S_LIJ, S_WIJ,
    S_LDG, S_CDG, S_SQ, S_WDG, S_LDV, S_CDV, S_DV, S_WDV,
    S_FIN, S_ABT
  } col_state_e;

endpackage

// File: rtl/chol_sqrt.sv
module chol_sqrt #(
  parameter int DW   = 32,
  parameter int FRAC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] val_i,
  output logic          done_o,
  output logic [DW-1:0] root_o
);
  localparam int RW = DW + FRAC;
  localparam int QW = RW / 2;
  localparam int CW = $clog2(QW + 1);

  logic          run_q, run_d, done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] rad_q, rad_d;
  logic [QW+1:0] rem_q, rem_d;
  logic [QW-1:0] root_q, root_d;
  logic [QW+3:0] rem_sh, trial, rem_nx;
  logic          ge;

  // restoring step: bring down two radicand bits, try (root<<2)|1
  always_comb begin
    rem_sh = {rem_q, rad_q[RW-1 -: 2]};
    trial  = {2'b00, root_q, 2'b01};
    ge     = rem_sh >= trial;
    rem_nx = ge ? rem_sh - trial : rem_sh;
  end

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    rad_d  = rad_q;
    rem_d  = rem_q;
    root_d = root_q;
    done_d = 1'b0;
    if (start_i) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      rad_d  = {val_i, {FRAC{1'b0}}};
      rem_d  = '0;
      root_d = '0;
    end else if (run_q) begin
      rad_d  = rad_q << 2;
      rem_d  = (QW+2)'(rem_nx);
      root_d = (root_q << 1) | QW'(ge);
      cnt_d  = cnt_q + 1'b1;
      if (cnt_q == CW'(QW - 1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rad_q  <= '0;
      rem_q  <= '0;
      root_q <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      rad_q  <= rad_d;
      rem_q  <= rem_d;
      root_q <= root_d;
    end
  end

  assign done_o = done_q;
  assign root_o = DW'(root_q);

  a_r5_sqrt_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/chol_div.sv
module chol_div #(
  parameter int DW   = 32,
  parameter int FRAC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [DW-1:0] quo_o
);
  localparam int NW = DW + FRAC;
  localparam int CW = $clog2(NW + 1);

  logic          run_q, run_d, done_q, done_d, neg_q, neg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NW-1:0] dvd_q, dvd_d, quo_q, quo_d;
  logic [DW-1:0] den_q, den_d, mag;
  logic [DW+1:0] r_q, r_d, r_sh, r_nx;

  // non-restoring step: add or subtract by sign of the partial remainder
  always_comb begin
    mag  = num_i[DW-1] ? DW'(-num_i) : num_i;
    r_sh = {r_q[DW:0], dvd_q[NW-1]};
    r_nx = r_q[DW+1] ? r_sh + {2'b00, den_q} : r_sh - {2'b00, den_q};
  end

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    dvd_d  = dvd_q;
    quo_d  = quo_q;
    den_d  = den_q;
    neg_d  = neg_q;
    r_d    = r_q;
    done_d = 1'b0;
    if (start_i) begin
      run_d = 1'b1;
      cnt_d = '0;
      dvd_d = {mag, {FRAC{1'b0}}};
      quo_d = '0;
      den_d = den_i;
      neg_d = num_i[DW-1];
      r_d   = '0;
    end else if (run_q) begin
      r_d   = r_nx;
      dvd_d = dvd_q << 1;
      quo_d = (quo_q << 1) | NW'(!r_nx[DW+1]);
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(NW - 1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      dvd_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      neg_q  <= 1'b0;
      r_q    <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      dvd_q  <= dvd_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
      neg_q  <= neg_d;
      r_q    <= r_d;
    end
  end

  assign done_o = done_q;
  assign quo_o  = neg_q ? DW'(-quo_q) : DW'(quo_q);

  a_r5_div_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/chol_col_engine.sv
module chol_col_engine
  import chol_pkg::*;
#(
  parameter int MAXN = 16,
  parameter int DW   = 32,
  parameter int FRAC = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [$clog2(MAXN)-1:0]    col_i,
  input  logic [$clog2(MAXN):0]      order_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       err_o,
  output logic                       rdy_set_o,
  output logic [$clog2(MAXN)-1:0]    rdy_col_o,
  input  logic [MAXN-1:0]            ready_i,
  output logic [2*$clog2(MAXN)-1:0]  mem_addr_o,
  output logic [DW-1:0]              mem_wdata_o,
  output logic                       mem_we_o,
  input  logic [DW-1:0]              mem_rdata_i
);
  localparam int IW = $clog2(MAXN);
  localparam int NW = IW + 1;

  col_state_e    st_q, st_d;
  logic [IW-1:0] col_q, col_d, k_q, k_d, i_q, i_d;
  logic [NW-1:0] n_q, n_d;
  logic [DW-1:0] ajk_q, ajk_d, aik_q, aik_d, diag_q, diag_d;
  logic          err_q, err_d;
  logic          last_row, k_last, col_last, diag_bad;
  logic          sq_start, sq_done, dv_start, dv_done;
  logic [DW-1:0] sq_root, dv_quo;
  logic signed [2*DW-1:0] prod;
  logic signed [DW-1:0]   upd;

  chol_sqrt #(.DW(DW), .FRAC(FRAC)) u_sqrt (
    .clk(clk), .rst_n(rst_n), .start_i(sq_start), .val_i(mem_rdata_i),
    .done_o(sq_done), .root_o(sq_root));

  chol_div #(.DW(DW), .FRAC(FRAC)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(dv_start), .num_i(mem_rdata_i),
    .den_i(diag_q), .done_o(dv_done), .quo_o(dv_quo));

  // column-modify datapath: A[i][j] - A[j][k]*A[i][k], rescaled
  always_comb begin
    prod = $signed(ajk_q) * $signed(aik_q);
    upd  = $signed(mem_rdata_i) - DW'(prod >>> FRAC);
  end

  always_comb begin
    last_row = ({1'b0, i_q} + 1'b1) == n_q;
    col_last = ({1'b0, col_q} + 1'b1) == n_q;
    k_last   = ({1'b0, k_q} + 1'b1) == {1'b0, col_q};
    diag_bad = mem_rdata_i[DW-1] || (mem_rdata_i == '0);
  end

  // next-state and counter logic
  always_comb begin
    st_d     = st_q;
    col_d    = col_q;
    n_d      = n_q;
    k_d      = k_q;
    i_d      = i_q;
    ajk_d    = ajk_q;
    aik_d    = aik_q;
    diag_d   = diag_q;
    err_d    = err_q;
    sq_start = 1'b0;
    dv_start = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        col_d = col_i;
        n_d   = order_i;
        k_d   = '0;
        err_d = 1'b0;
        st_d  = (col_i == '0) ? S_LDG : S_WAIT;
      end
      S_WAIT: if (ready_i[k_q]) st_d = S_LJK;
      S_LJK:  st_d = S_CJK;
      S_CJK: begin
        ajk_d = mem_rdata_i;
        i_d   = col_q;
        st_d  = S_LIK;
      end
      S_LIK:  st_d = S_LIJ;
      S_LIJ: begin
        aik_d = mem_rdata_i;
        st_d  = S_WIJ;
      end
      S_WIJ: if (last_row) begin
        k_d  = k_q + 1'b1;
        st_d = k_last ? S_LDG : S_WAIT;
      end else begin
        i_d  = i_q + 1'b1;
        st_d = S_LIK;
      end
      S_LDG:  st_d = S_CDG;
      S_CDG: if (diag_bad) begin
        err_d = 1'b1;
        st_d  = S_ABT;
      end else begin
        sq_start = 1'b1;
        st_d     = S_SQ;
      end
      S_SQ: if (sq_done) begin
        diag_d = sq_root;
        st_d   = S_WDG;
      end
      S_WDG: begin
        i_d  = col_q + 1'b1;
        st_d = col_last ? S_FIN : S_LDV;
      end
      S_LDV:  st_d = S_CDV;
      S_CDV: begin
        dv_start = 1'b1;
        st_d     = S_DV;
      end
      S_DV: if (dv_done) begin
        aik_d = dv_quo;
        st_d  = S_WDV;
      end
      S_WDV: if (last_row) st_d = S_FIN;
      else begin
        i_d  = i_q + 1'b1;
        st_d = S_LDV;
      end
      S_FIN, S_ABT: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      col_q  <= '0;
      n_q    <= '0;
      k_q    <= '0;
      i_q    <= '0;
      ajk_q  <= '0;
      aik_q  <= '0;
      diag_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      col_q  <= col_d;
      n_q    <= n_d;
      k_q    <= k_d;
      i_q    <= i_d;
      ajk_q  <= ajk_d;
      aik_q  <= aik_d;
      diag_q <= diag_d;
      err_q  <= err_d;
    end
  end

  // memory port decode
  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    unique case (st_q)
      S_LJK:        mem_addr_o = {col_q, k_q};
      S_LIK:        mem_addr_o = {i_q, k_q};
      S_LIJ:        mem_addr_o = {i_q, col_q};
      S_WIJ: begin
        mem_addr_o  = {i_q, col_q};
        mem_wdata_o = upd;
        mem_we_o    = 1'b1;
      end
      S_LDG:        mem_addr_o = {col_q, col_q};
      S_WDG: begin
        mem_addr_o  = {col_q, col_q};
        mem_wdata_o = diag_q;
        mem_we_o    = 1'b1;
      end
      S_LDV:        mem_addr_o = {i_q, col_q};
      S_WDV: begin
        mem_addr_o  = {i_q, col_q};
        mem_wdata_o = aik_q;
        mem_we_o    = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = (st_q == S_FIN) || (st_q == S_ABT);
  assign rdy_set_o = (st_q == S_FIN);
  assign rdy_col_o = col_q;
  assign err_o     = err_q;

  a_r1_we_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);
  a_r3_cdiv_after_cmod: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_LDG) |-> (k_q == col_q));
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && !ready_i[k_q]) |=> (st_q == S_WAIT && !mem_we_o));
  a_r7_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_set_o |=> !rdy_set_o);
  a_r8_no_ready_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_set_o |-> !err_o);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

endmodule

// File: tb/test_chol_col_engine.sv
module test_chol_col_engine;
  localparam int N = 16;

  logic        clk, rst_n, start, busy, done, err, rdy_set, we;
  logic [3:0]  col, rdy_col;
  logic [4:0]  order;
  logic [15:0] ready;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;

  logic               ld_en;
  logic [7:0]         ld_addr;
  logic signed [31:0] ld_data;
  logic signed [31:0] mem [256];
  logic signed [31:0] img [256];
  int                 wr_cnt;
  int                 errs, checks;

  chol_col_engine i_chol_col_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start), .col_i(col), .order_i(order),
    .busy_o(busy), .done_o(done), .err_o(err), .rdy_set_o(rdy_set),
    .rdy_col_o(rdy_col), .ready_i(ready), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_we_o(we), .mem_rdata_i(rdata));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (we) begin
      mem[addr] <= wdata;
      wr_cnt    <= wr_cnt + 1;
    end
    rdata <= mem[addr];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint isqrt(input longint v);
    longint lo = 0, hi = 64'd1 << 24;
    while (lo < hi) begin
      longint mid = (lo + hi + 1) / 2;
      if (mid * mid <= v) lo = mid; else hi = mid - 1;
    end
    return lo;
  endfunction

  // reference column step on the expected image
  task automatic ref_col(input int j, input int n, output bit e);
    longint d, r;
    e = 1'b0;
    for (int k = 0; k < j; k++) begin
      longint ajk = img[j*N+k];
      for (int i = j; i < n; i++) begin
        longint p = ajk * longint'(img[i*N+k]);
        img[i*N+j] = 32'(longint'(img[i*N+j]) - (p >>> 16));
      end
    end
    d = img[j*N+j];
    if (d <= 0) begin
      e = 1'b1;
      return;
    end
    r = isqrt(d <<< 16);
    img[j*N+j] = 32'(r);
    for (int i = j + 1; i < n; i++)
      img[i*N+j] = 32'((longint'(img[i*N+j]) <<< 16) / r);
  endtask

  task automatic load_img();
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 8'(a); ld_data = img[a];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic fill_sentinel();
    for (int a = 0; a < 256; a++) img[a] = 32'sh3000_0000 + a;
  endtask

  // A = L*L^T with L in quarter steps; diagonal of L from 1 to 3
  task automatic gen_rand(input int n);
    int lq [16][16];
    fill_sentinel();
    for (int i = 0; i < n; i++)
      for (int k = 0; k <= i; k++)
        lq[i][k] = (i == k) ? 4 * (1 + int'($urandom % 3)) : int'($urandom % 9) - 4;
    for (int i = 0; i < n; i++)
      for (int j = 0; j <= i; j++) begin
        int s = 0;
        for (int k = 0; k <= j; k++) s += lq[i][k] * lq[j][k];
        img[i*N+j] = s * 4096;
      end
  endtask

  task automatic run_col(input int j, input int n, input logic [15:0] mask,
                         input bit stall, input bit dbl);
    bit e;
    int wr0, pulses, cyc, bad;
    logic [3:0] rc;
    wr0 = wr_cnt;
    ref_col(j, n, e);
    @(negedge clk);
    start = 1'b1; col = 4'(j); order = 5'(n);
    ready = stall ? (mask & ~16'h0001) : mask;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    if (stall) begin
      repeat (40) @(negedge clk);
      chk(busy && wr_cnt == wr0, "R4 stalled without writes", wr_cnt - wr0, 0);
      ready = mask;
    end
    pulses = 0; cyc = 0; rc = '0;
    while (!done && cyc < 20000) begin
      if (dbl && cyc == 3) begin start = 1'b1; col = 4'd0; end
      else start = 1'b0;
      if (rdy_set) pulses++;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc < 20000, "R10 watchdog on column run", cyc, 20000);
    if (rdy_set) begin pulses++; rc = rdy_col; end
    chk(err == e, "R8 error flag", err, e);
    chk(pulses == (e ? 0 : 1), "R7 completion pulse count", pulses, e ? 0 : 1);
    if (!e) chk(rc == 4'(j), "R7 completion column", rc, j);
    if (j == 0 && mask == 16'h0 && !e) chk(pulses == 1, "R6 column 0 without ready", pulses, 1);
    @(negedge clk);
    chk(!busy && !done, "R10 idle after done", {busy, done}, 0);
    for (int i = j; i < n; i++)
      chk(mem[i*N+j] == img[i*N+j], "R2 R3 R5 column entry", mem[i*N+j], img[i*N+j]);
    bad = 0;
    for (int a = 0; a < 256; a++) if (mem[a] != img[a]) bad++;
    chk(bad == 0, dbl ? "R9 R11 memory image" : "R11 memory image", bad, 0);
  endtask

  task automatic factor_all(input int n, input int stall_col, input int dbl_col);
    logic [15:0] m = '0;
    for (int j = 0; j < n; j++) begin
      run_col(j, n, m, j == stall_col, j == dbl_col);
      m[j] = 1'b1;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R10 global watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    errs = 0; checks = 0; wr_cnt = 0;
    start = 1'b0; col = '0; order = 5'd1; ready = '0;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, err, we, rdy_set} == 5'b0, "R1 reset state",
        {busy, done, err, we, rdy_set}, 0);

    // order 1: sqrt of 4.0 is 2.0
    fill_sentinel();
    img[0] = 32'sd4 <<< 16;
    load_img();
    run_col(0, 1, 16'h0, 1'b0, 1'b0);
    chk(mem[0] == 32'sd131072, "R5 sqrt of 4.0", mem[0], 131072);

    // random order 6 with a stall and an ignored start
    gen_rand(6);
    load_img();
    factor_all(6, 2, 3);

    // random full order 16
    gen_rand(16);
    load_img();
    factor_all(16, 5, -1);

    // random order 9
    gen_rand(9);
    load_img();
    factor_all(9, -1, 7);

    // negative diagonal, zero diagonal, then recovery
    fill_sentinel();
    img[0] = -32'sd65536; img[16] = 32'sd123; img[17] = 32'sd5 <<< 16;
    load_img();
    run_col(0, 2, 16'h0, 1'b0, 1'b0);
    chk(mem[16] == 32'sd123, "R8 below-diagonal untouched", mem[16], 123);
    img[0] = 32'sd0;
    load_img();
    run_col(0, 2, 16'h0, 1'b0, 1'b0);
    img[0] = 32'sd1 <<< 16;
    load_img();
    run_col(0, 2, 16'h0, 1'b0, 1'b0);
    chk(err == 1'b0, "R8 error cleared by next start", err, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule